// File: doc/BRIEF.md
# Modulated Synthesizer Word Generator

This block builds the control word for a fractional-N frequency synthesizer from a stored configuration and the live transmit data bit. It takes a 15-bit frequency setting, an 8-bit deviation setting, a band bit, a modulation-type bit and the data bit. From these it produces three outputs: a selector for the integer part of the division ratio, a fractional numerator in units of 1/32768, and a keying signal for the power amplifier. The numerator is always odd, so the half-step offset in the division ratio is exact.

In frequency-shift mode the amplifier stays on, and the data bit chooses between the space word (no deviation) and the mark word (full deviation). In amplitude-shift mode the carrier moves to the frequency-shift centre by adding half the deviation, rounded down, and the data bit switches the amplifier on and off. A flag reports a frequency setting outside the clean range or a zero deviation. All outputs are registered on the reference clock and load only while the sequencer holds the update enable high.

Top module: `synth_word_gen`

## Requirements
- R1: While rst_ni is low, int_sel_o, frac_num_o, pa_key_o and cfg_bad_o are all 0.
- R2: int_sel_o takes the value of band_hi_i, where 0 selects an integer part of 24 and 1 selects 32.5.
- R3: In frequency-shift mode (mod_ask_i = 0) with tx_data_i = 0 (space), frac_num_o = 2*freq_i + 1.
- R4: In frequency-shift mode with tx_data_i = 1 (mark), frac_num_o = 2*(freq_i + fsep_i) + 1. This includes the largest case, freq_i = 32767 with fsep_i = 255, which gives 66045.
- R5: In amplitude-shift mode (mod_ask_i = 1), frac_num_o = 2*(freq_i + floor(fsep_i/2)) + 1 whatever the value of tx_data_i. An odd fsep_i is rounded down.
- R6: In amplitude-shift mode pa_key_o equals tx_data_i. In frequency-shift mode pa_key_o is 1.
- R7: cfg_bad_o is 1 exactly when freq_i < 2500, freq_i > 22000 or fsep_i = 0. The values 2500 and 22000 themselves are valid.
- R8: While upd_en_i is low at a rising clock edge, all outputs keep their previous values, whatever the other inputs do.
- R9: Outputs change one clock after the edge at which upd_en_i is high, and they reflect the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_en_i | input | 1 | Output update enable from the sequencer |
| freq_i | input | 15 | Frequency setting |
| fsep_i | input | 8 | Deviation setting |
| band_hi_i | input | 1 | Band select: 0 gives an integer part of 24, 1 gives 32.5 |
| mod_ask_i | input | 1 | Modulation type: 0 is frequency shift, 1 is amplitude shift |
| tx_data_i | input | 1 | Transmit data bit |
| int_sel_o | output | 1 | Integer-part selector |
| frac_num_o | output | 17 | Fractional numerator in units of 1/32768 |
| pa_key_o | output | 1 | Amplifier keying |
| cfg_bad_o | output | 1 | Setting out of range or zero deviation |

## Verification
The bench builds the block with its default widths, a 15-bit frequency field and an 8-bit deviation field, and with the default limits of 2500 and 22000. With these widths the full mark sum, 32767 plus 255, is reachable, so the top bit of the 17-bit numerator gets exercised. The range limits can be probed one step inside and one step outside each bound. Odd and even deviations are both driven, so the rounding-down in amplitude-shift mode shows up at the output.

// File: rtl/synth_word_pkg.sv
package synth_word_pkg;
  typedef enum logic {MOD_FSK = 1'b0, MOD_ASK = 1'b1} mod_e;
  typedef enum logic {BAND_LO = 1'b0, BAND_HI = 1'b1} band_e;
endpackage

// File: rtl/dev_offset_sel.sv
module dev_offset_sel
  import synth_word_pkg::*;
#(
  parameter int FSEP_W = 8
) (
  input  logic [FSEP_W-1:0] fsep_i,
  input  logic              mod_ask_i,
  input  logic              tx_data_i,
  output logic [FSEP_W-1:0] off_o,
  output logic              pa_key_o
);
  mod_e mode;
  assign mode = mod_e'(mod_ask_i);

  always_comb begin
    unique case (mode)
      MOD_ASK: begin
        off_o    = fsep_i >> 1;  // centre of the two shift tones, rounded down
        pa_key_o = tx_data_i;
      end
      default: begin
        off_o    = tx_data_i ? fsep_i : '0;
        pa_key_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/frac_word_calc.sv
module frac_word_calc #(
  parameter int FREQ_W = 15,
  parameter int FSEP_W = 8,
  localparam int SUM_W  = FREQ_W + 1,
  localparam int FRAC_W = FREQ_W + 2
) (
  input  logic [FREQ_W-1:0] freq_i,
  input  logic [FSEP_W-1:0] off_i,
  output logic [FRAC_W-1:0] frac_o
);
  logic [SUM_W-1:0] sum;

  generate
    if (FSEP_W < SUM_W) begin : g_narrow
      assign sum = {1'b0, freq_i} + SUM_W'(off_i);
    end else begin : g_wide
      logic [FSEP_W:0] wide;
      assign wide = (FSEP_W + 1)'(freq_i) + (FSEP_W + 1)'(off_i);
      assign sum  = wide[SUM_W-1:0];
    end
  endgenerate

  // doubled word plus one keeps the half step exact
  assign frac_o = {sum, 1'b1};
endmodule

// File: rtl/cfg_range_chk.sv
module cfg_range_chk #(
  parameter int FREQ_W   = 15,
  parameter int FSEP_W   = 8,
  parameter int FREQ_MIN = 2500,
  parameter int FREQ_MAX = 22000
) (
  input  logic [FREQ_W-1:0] freq_i,
  input  logic [FSEP_W-1:0] fsep_i,
  output logic              bad_o
);
  localparam logic [FREQ_W-1:0] LO = FREQ_W'(FREQ_MIN);
  localparam logic [FREQ_W-1:0] HI = FREQ_W'(FREQ_MAX);

  assign bad_o = (freq_i < LO) || (freq_i > HI) || (fsep_i == '0);
endmodule

// File: rtl/synth_word_gen.sv
module synth_word_gen #(
  parameter int FREQ_W   = 15,
  parameter int FSEP_W   = 8,
  parameter int FREQ_MIN = 2500,
  parameter int FREQ_MAX = 22000,
  localparam int FRAC_W  = FREQ_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_en_i,
  input  logic [FREQ_W-1:0] freq_i,
  input  logic [FSEP_W-1:0] fsep_i,
  input  logic              band_hi_i,
  input  logic              mod_ask_i,
  input  logic              tx_data_i,
  output logic              int_sel_o,
  output logic [FRAC_W-1:0] frac_num_o,
  output logic              pa_key_o,
  output logic              cfg_bad_o
);
  logic [FSEP_W-1:0] off;
  logic              pa_d;
  logic [FRAC_W-1:0] frac_d;
  logic              bad_d;

  dev_offset_sel #(.FSEP_W(FSEP_W)) u_off (
    .fsep_i    (fsep_i),
    .mod_ask_i (mod_ask_i),
    .tx_data_i (tx_data_i),
    .off_o     (off),
    .pa_key_o  (pa_d)
  );

  frac_word_calc #(.FREQ_W(FREQ_W), .FSEP_W(FSEP_W)) u_frac (
    .freq_i (freq_i),
    .off_i  (off),
    .frac_o (frac_d)
  );

  cfg_range_chk #(
    .FREQ_W(FREQ_W), .FSEP_W(FSEP_W), .FREQ_MIN(FREQ_MIN), .FREQ_MAX(FREQ_MAX)
  ) u_chk (
    .freq_i (freq_i),
    .fsep_i (fsep_i),
    .bad_o  (bad_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_sel_o  <= 1'b0;
      frac_num_o <= '0;
      pa_key_o   <= 1'b0;
      cfg_bad_o  <= 1'b0;
    end else if (upd_en_i) begin
      int_sel_o  <= band_hi_i;
      frac_num_o <= frac_d;
      pa_key_o   <= pa_d;
      cfg_bad_o  <= bad_d;
    end
  end
endmodule

// File: rtl/synth_word_gen_chk.sv
module synth_word_gen_chk #(
  parameter int FREQ_W  = 15,
  parameter int FSEP_W  = 8,
  localparam int FRAC_W = FREQ_W + 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              upd_en_i,
  input logic [FREQ_W-1:0] freq_i,
  input logic [FSEP_W-1:0] fsep_i,
  input logic              band_hi_i,
  input logic              mod_ask_i,
  input logic              tx_data_i,
  input logic              int_sel_o,
  input logic [FRAC_W-1:0] frac_num_o,
  input logic              pa_key_o,
  input logic              cfg_bad_o
);
  logic started_q, loaded_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      loaded_q  <= 1'b0;
    end else begin
      started_q <= 1'b1;
      if (upd_en_i) loaded_q <= 1'b1;
    end
  end

  always_comb begin
    if (!rst_ni) begin
      AST_RESET_ZERO: assert (!int_sel_o && frac_num_o == '0 && !pa_key_o && !cfg_bad_o); // R1
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q && !$past(upd_en_i) |-> $stable(frac_num_o) && $stable(int_sel_o)
      && $stable(pa_key_o) && $stable(cfg_bad_o)); // R8

  AST_BAND_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q && $past(upd_en_i) |-> int_sel_o == $past(band_hi_i)); // R2

  AST_FRAC_ODD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loaded_q |-> frac_num_o[0]); // R3

  AST_MARK_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q && $past(upd_en_i && !mod_ask_i && tx_data_i)
      |-> frac_num_o == FRAC_W'(2 * ($past(int'(freq_i)) + $past(int'(fsep_i))) + 1)); // R4

  AST_FSK_PA_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q && $past(upd_en_i && !mod_ask_i) |-> pa_key_o); // R6

  AST_ASK_PA_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q && $past(upd_en_i && mod_ask_i) |-> pa_key_o == $past(tx_data_i)); // R6

  AST_ZERO_DEV_BAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q && $past(upd_en_i && fsep_i == '0) |-> cfg_bad_o); // R7
endmodule

bind synth_word_gen synth_word_gen_chk #(.FREQ_W(FREQ_W), .FSEP_W(FSEP_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .upd_en_i   (upd_en_i),
  .freq_i     (freq_i),
  .fsep_i     (fsep_i),
  .band_hi_i  (band_hi_i),
  .mod_ask_i  (mod_ask_i),
  .tx_data_i  (tx_data_i),
  .int_sel_o  (int_sel_o),
  .frac_num_o (frac_num_o),
  .pa_key_o   (pa_key_o),
  .cfg_bad_o  (cfg_bad_o)
);

// File: tb/synth_word_gen_tb_top.sv
module synth_word_gen_tb_top;
  localparam int FREQ_W = 15;
  localparam int FSEP_W = 8;
  localparam int FRAC_W = FREQ_W + 2;

  typedef struct {
    logic        sel;
    int          frac;
    logic        pa;
    logic        bad;
    string       tag;
  } exp_t;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              upd_en_i = 1'b0;
  logic [FREQ_W-1:0] freq_i = '0;
  logic [FSEP_W-1:0] fsep_i = '0;
  logic              band_hi_i = 1'b0;
  logic              mod_ask_i = 1'b0;
  logic              tx_data_i = 1'b0;
  logic              int_sel_o;
  logic [FRAC_W-1:0] frac_num_o;
  logic              pa_key_o;
  logic              cfg_bad_o;

  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_t exp_q[$];
  exp_t last;

  always #10 clk_i = ~clk_i;

  synth_word_gen dut_i (
    .clk_i, .rst_ni, .upd_en_i, .freq_i, .fsep_i, .band_hi_i,
    .mod_ask_i, .tx_data_i, .int_sel_o, .frac_num_o, .pa_key_o, .cfg_bad_o
  );

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the expected result
  task automatic drive(input int fr, input int fs, input bit band, input bit ask,
                       input bit dat, input bit en, input string tag);
    exp_t e;
    int   off;
    @(negedge clk_i);
    freq_i = FREQ_W'(fr); fsep_i = FSEP_W'(fs); band_hi_i = band;
    mod_ask_i = ask; tx_data_i = dat; upd_en_i = en;
    if (en) begin
      off    = ask ? fs / 2 : (dat ? fs : 0);
      e.sel  = band;
      e.frac = 2 * (fr + off) + 1;
      e.pa   = ask ? dat : 1'b1;
      e.bad  = (fr < 2500) || (fr > 22000) || (fs == 0);
    end else begin
      e = last;
    end
    e.tag = tag;
    last  = e;
    exp_q.push_back(e);
  endtask

  // monitor: compares after each rising edge
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        cmp(e.tag, "int_sel", int'(int_sel_o), int'(e.sel));
        cmp(e.tag, "frac", int'(frac_num_o), e.frac);
        cmp(e.tag, "pa_key", int'(pa_key_o), int'(e.pa));
        cmp(e.tag, "cfg_bad", int'(cfg_bad_o), int'(e.bad));
      end
    end
  end

  initial begin
    #200000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    last = '{sel: 1'b0, frac: 0, pa: 1'b0, bad: 1'b0, tag: "R1"};
    freq_i = 15'd5000; fsep_i = 8'd9; upd_en_i = 1'b1;
    repeat (3) @(posedge clk_i);
    #5;
    cmp("R1", "int_sel", int'(int_sel_o), 0);
    cmp("R1", "frac", int'(frac_num_o), 0);
    cmp("R1", "pa_key", int'(pa_key_o), 0);
    cmp("R1", "cfg_bad", int'(cfg_bad_o), 0);
    @(negedge clk_i);
    upd_en_i = 1'b0;
    rst_ni = 1'b1;

    drive(3730, 100, 0, 0, 0, 1, "R3_space_band_lo");
    drive(3730, 100, 0, 0, 1, 1, "R4_mark_band_lo");
    drive(14342, 100, 1, 1, 1, 1, "R5_ask_on_R2");
    drive(14342, 100, 1, 1, 0, 1, "R6_ask_off");
    drive(14342, 101, 1, 1, 1, 1, "R5_odd_dev");
    drive(9000, 1, 0, 1, 0, 1, "R5_dev_one");
    drive(32767, 255, 1, 0, 1, 1, "R4_max_word");
    drive(32767, 255, 1, 0, 0, 1, "R3_space_max");
    drive(2499, 10, 0, 0, 1, 1, "R7_below_min");
    drive(2500, 10, 0, 0, 1, 1, "R7_at_min");
    drive(22000, 10, 0, 0, 1, 1, "R7_at_max");
    drive(22001, 10, 0, 0, 1, 1, "R7_above_max");
    drive(12000, 0, 0, 0, 1, 1, "R7_zero_dev");
    drive(12000, 40, 1, 0, 0, 1, "R9_load");
    drive(600, 3, 0, 1, 0, 0, "R8_hold_a");
    drive(30000, 0, 0, 1, 1, 0, "R8_hold_b");
    drive(600, 3, 0, 1, 0, 1, "R9_reload");
    for (int i = 0; i < 40; i++) begin
      drive(2500 + i * 517, (i * 37) % 256, i[0], i[1], i[2], (i % 5) != 4, "R9_sweep");
    end
    @(negedge clk_i);
    @(negedge clk_i);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule